// File: doc/BRIEF.md
# Shadow RAM Region Access Decoder

This block sits on the memory path of a system controller and decides, for each memory cycle, where it is served. Cycles that fall in the upper legacy window (0xC0000 to 0xFFFFF) go either to internal shadow DRAM or to the external expansion bus, according to a bank of four configuration bytes. All other addresses are always served internally.

The window has two parts. From 0xC0000 to 0xEFFFF there are twelve 16 KB segments, and each segment has its own read-enable bit and write-enable bit. The 64 KB area from 0xF0000 to 0xFFFFF has one read enable and one write enable. Reads and writes are decoded separately. A segment can therefore be read from the bus while writes to it land in shadow DRAM, which is the usual step when ROM contents are copied into shadow memory.

Configuration bytes are written through a simple byte-write port addressed by configuration offset. The routing outputs are combinational from the access inputs and the stored configuration. A configuration write first affects routing in the cycle after the clock edge that captures it.

Top module: `shadow_route_top`

## Requirements
- R1: After reset all four configuration bytes are zero, so every read and every write inside 0xC0000–0xFFFFF is routed to the external bus.
- R2: An access with address below 0xC0000 is routed internally whatever the configuration holds.
- R3: Segment i (0 to 11) covers 0xC0000 + i·0x4000 up to 0x3FFF above that, and is controlled by the byte at offset 0x44 + ((i>>2) XOR 3). Segments 0–3 use 0x47, segments 4–7 use 0x46 and segments 8–11 use 0x45.
- R4: Inside a segment's control byte, bit (i mod 4) enables internal writes and bit (i mod 4)+4 enables internal reads.
- R5: The 0xF0000–0xFFFFF area is routed internally for writes when bit 0 of offset 0x44 is 1, and for reads when bit 1 of offset 0x44 is 1. The other bits of that byte have no effect on this area.
- R6: When the enable bit that applies is 0, the access is routed to the external bus.
- R7: The read and write enables of a segment act independently. The qualifier acc_wr=1 selects the write enable and acc_wr=0 selects the read enable.
- R8: While acc_valid is 1, exactly one of int_sel and ext_sel is 1. While acc_valid is 0, both are 0.
- R9: A configuration write (cfg_we=1) to offset 0x44–0x47 changes routing starting with the cycle after the clock edge that captures it, and not before. A write to any other offset has no effect on routing.
- R10: Without a configuration write, routing for an unchanged access stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_off | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration byte data |
| acc_valid | input | 1 | Memory cycle valid |
| acc_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| acc_addr | input | 20 | Memory cycle address |
| int_sel | output | 1 | Cycle served by internal memory |
| ext_sel | output | 1 | Cycle forwarded to the external bus |

## Verification
The bench targets the XOR swizzle of the byte index. A decoder without the swizzle would take segments 0–3 from byte 0x44, so writing 0x47 would leave 0xC0000 on the external bus. It also checks the split between the read nibble and the write nibble, since swapping them routes a write-only segment internally for reads. The edges of the window are tested: 0xBFFFF must stay internal, and 0xEFFFF and 0xFFFFF must decode to the last segment and to the top area. A decoder with an off-by-one bound would misroute one of these addresses. Writes to offsets next to the bank (0x43, 0x48) must change nothing, and a write must not affect routing until the clock edge that captures it.

// File: rtl/shadow_route_pkg.sv
package shadow_route_pkg;

  // Width of one configuration byte.
  localparam int CFG_BYTE_W = 8;

  // Which part of the address space an access falls into.
  typedef enum logic [1:0] {
    AREA_PLAIN = 2'd0,  // below the shadow window: always internal
    AREA_SEG   = 2'd1,  // one of the 16 KB segments
    AREA_TOP   = 2'd2   // the single top area
  } area_e;

endpackage

// File: rtl/shadow_rst_sync.sv
module shadow_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/shadow_cfg_bank.sv
module shadow_cfg_bank #(
  parameter int NUM_BYTES = 4,
  parameter int OFF_W     = 8,
  parameter int BASE_OFF  = 'h44,
  localparam int BYTE_W   = shadow_route_pkg::CFG_BYTE_W,
  localparam int FLAT_W   = NUM_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [FLAT_W-1:0] cfg_flat
);

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    logic              load_en;
    logic [BYTE_W-1:0] byte_q;
    logic [BYTE_W-1:0] byte_d;

    // Clock enable: this byte's offset is addressed by a write.
    assign load_en = wr_en && (wr_off == OFF_W'(BASE_OFF + b));

    always_comb begin
      byte_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (load_en) begin
        byte_q <= byte_d;
      end
    end

    assign cfg_flat[b*BYTE_W +: BYTE_W] = byte_q;
  end

endmodule

// File: rtl/shadow_seg_map.sv
module shadow_seg_map #(
  parameter int NUM_BYTES    = 4,
  parameter int NUM_SEG      = 12,
  parameter int SEG_PER_BYTE = 4,
  localparam int BYTE_W      = shadow_route_pkg::CFG_BYTE_W,
  localparam int FLAT_W      = NUM_BYTES * BYTE_W
) (
  input  logic [FLAT_W-1:0]  cfg_flat,
  output logic [NUM_SEG-1:0] seg_wr_en,
  output logic [NUM_SEG-1:0] seg_rd_en,
  output logic               top_wr_en,
  output logic               top_rd_en
);

  // Segment enables: byte index is swizzled so the lowest segments live
  // in the highest byte of the bank.
  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    localparam int BYTE_IDX = (i / SEG_PER_BYTE) ^ (NUM_BYTES - 1);
    localparam int WR_BIT   = BYTE_IDX * BYTE_W + (i % SEG_PER_BYTE);
    localparam int RD_BIT   = WR_BIT + SEG_PER_BYTE;
    assign seg_wr_en[i] = cfg_flat[WR_BIT];
    assign seg_rd_en[i] = cfg_flat[RD_BIT];
  end

  // The top area uses the two low bits of the first byte.
  assign top_wr_en = cfg_flat[0];
  assign top_rd_en = cfg_flat[1];

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^cfg_flat[BYTE_W-1:2];

endmodule

// File: rtl/shadow_addr_classify.sv
module shadow_addr_classify
  import shadow_route_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int SEG_SHIFT   = 14,
  parameter int NUM_SEG     = 12,
  parameter int REGION_BASE = 'hC0000,
  localparam int SEG_IDX_W  = $clog2(NUM_SEG),
  localparam int TOP_BASE   = REGION_BASE + (NUM_SEG << SEG_SHIFT)
) (
  input  logic [ADDR_W-1:0]    addr,
  output area_e                area,
  output logic [SEG_IDX_W-1:0] seg_idx
);

  logic [ADDR_W-1:0] offset;

  assign offset  = addr - ADDR_W'(REGION_BASE);
  assign seg_idx = offset[SEG_SHIFT +: SEG_IDX_W];

  always_comb begin
    if (addr >= ADDR_W'(TOP_BASE)) begin
      area = AREA_TOP;
    end else if (addr >= ADDR_W'(REGION_BASE)) begin
      area = AREA_SEG;
    end else begin
      area = AREA_PLAIN;
    end
  end

  logic unused_off_bits;
  assign unused_off_bits = ^{offset[SEG_SHIFT-1:0], offset[ADDR_W-1:SEG_SHIFT+SEG_IDX_W]};

endmodule

// File: rtl/shadow_route_sel.sv
module shadow_route_sel
  import shadow_route_pkg::*;
#(
  parameter int NUM_SEG    = 12,
  localparam int SEG_IDX_W = $clog2(NUM_SEG),
  localparam int SEG_SLOTS = 1 << SEG_IDX_W
) (
  input  logic                 acc_valid,
  input  logic                 acc_wr,
  input  area_e                area,
  input  logic [SEG_IDX_W-1:0] seg_idx,
  input  logic [NUM_SEG-1:0]   seg_wr_en,
  input  logic [NUM_SEG-1:0]   seg_rd_en,
  input  logic                 top_wr_en,
  input  logic                 top_rd_en,
  output logic                 int_sel,
  output logic                 ext_sel
);

  // Pad to a power of two so any index value selects a defined bit.
  logic [SEG_SLOTS-1:0] wr_pad;
  logic [SEG_SLOTS-1:0] rd_pad;
  logic                 serve_int;

  assign wr_pad = SEG_SLOTS'(seg_wr_en);
  assign rd_pad = SEG_SLOTS'(seg_rd_en);

  always_comb begin
    unique case (area)
      AREA_TOP: serve_int = acc_wr ? top_wr_en : top_rd_en;
      AREA_SEG: serve_int = acc_wr ? wr_pad[seg_idx] : rd_pad[seg_idx];
      default:  serve_int = 1'b1;
    endcase
  end

  assign int_sel = acc_valid &  serve_int;
  assign ext_sel = acc_valid & ~serve_int;

endmodule

// File: rtl/shadow_route_top.sv
module shadow_route_top
  import shadow_route_pkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int OFF_W        = 8,
  parameter int NUM_BYTES    = 4,
  parameter int BASE_OFF     = 'h44,
  parameter int NUM_SEG      = 12,
  parameter int SEG_PER_BYTE = 4,
  parameter int SEG_SHIFT    = 14,
  parameter int REGION_BASE  = 'hC0000,
  localparam int BYTE_W      = CFG_BYTE_W,
  localparam int FLAT_W      = NUM_BYTES * BYTE_W,
  localparam int SEG_IDX_W   = $clog2(NUM_SEG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [OFF_W-1:0]  cfg_off,
  input  logic [BYTE_W-1:0] cfg_wdata,
  input  logic              acc_valid,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              int_sel,
  output logic              ext_sel
);

  logic                 rst_n_sync;
  logic [FLAT_W-1:0]    cfg_flat;
  logic [NUM_SEG-1:0]   seg_wr_en;
  logic [NUM_SEG-1:0]   seg_rd_en;
  logic                 top_wr_en;
  logic                 top_rd_en;
  area_e                area;
  logic [SEG_IDX_W-1:0] seg_idx;

  shadow_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  shadow_cfg_bank #(
    .NUM_BYTES (NUM_BYTES),
    .OFF_W     (OFF_W),
    .BASE_OFF  (BASE_OFF)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .wr_en    (cfg_we),
    .wr_off   (cfg_off),
    .wr_data  (cfg_wdata),
    .cfg_flat (cfg_flat)
  );

  shadow_seg_map #(
    .NUM_BYTES    (NUM_BYTES),
    .NUM_SEG      (NUM_SEG),
    .SEG_PER_BYTE (SEG_PER_BYTE)
  ) u_map (
    .cfg_flat  (cfg_flat),
    .seg_wr_en (seg_wr_en),
    .seg_rd_en (seg_rd_en),
    .top_wr_en (top_wr_en),
    .top_rd_en (top_rd_en)
  );

  shadow_addr_classify #(
    .ADDR_W      (ADDR_W),
    .SEG_SHIFT   (SEG_SHIFT),
    .NUM_SEG     (NUM_SEG),
    .REGION_BASE (REGION_BASE)
  ) u_cls (
    .addr    (acc_addr),
    .area    (area),
    .seg_idx (seg_idx)
  );

  shadow_route_sel #(
    .NUM_SEG (NUM_SEG)
  ) u_sel (
    .acc_valid (acc_valid),
    .acc_wr    (acc_wr),
    .area      (area),
    .seg_idx   (seg_idx),
    .seg_wr_en (seg_wr_en),
    .seg_rd_en (seg_rd_en),
    .top_wr_en (top_wr_en),
    .top_rd_en (top_rd_en),
    .int_sel   (int_sel),
    .ext_sel   (ext_sel)
  );

endmodule

// File: rtl/shadow_route_chk.sv
module shadow_route_chk #(
  parameter int ADDR_W      = 20,
  parameter int OFF_W       = 8,
  parameter int BASE_OFF    = 'h44,
  parameter int NUM_BYTES   = 4,
  parameter int REGION_BASE = 'hC0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [OFF_W-1:0]  cfg_off,
  input logic              acc_valid,
  input logic              acc_wr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              int_sel,
  input logic              ext_sel
);

  logic acc_same;
  logic off_in_bank;

  assign acc_same    = 1'b1;
  assign off_in_bank = (cfg_off >= OFF_W'(BASE_OFF)) &&
                       (cfg_off <= OFF_W'(BASE_OFF + NUM_BYTES - 1));

  // R8
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $countones({int_sel, ext_sel}) == 1);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!int_sel && !ext_sel));

  // R2
  low_internal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (acc_addr < ADDR_W'(REGION_BASE))) |-> int_sel);

  // R10
  hold_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_same && !$past(cfg_we) && $stable(acc_addr) && $stable(acc_wr) && $stable(acc_valid))
      |-> ($stable(int_sel) && $stable(ext_sel)));

  // R9
  foreign_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_we) && !$past(off_in_bank) && $stable(acc_addr) && $stable(acc_wr) && $stable(acc_valid))
      |-> ($stable(int_sel) && $stable(ext_sel)));

endmodule

bind shadow_route_top shadow_route_chk #(
  .ADDR_W      (ADDR_W),
  .OFF_W       (OFF_W),
  .BASE_OFF    (BASE_OFF),
  .NUM_BYTES   (NUM_BYTES),
  .REGION_BASE (REGION_BASE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_off   (cfg_off),
  .acc_valid (acc_valid),
  .acc_wr    (acc_wr),
  .acc_addr  (acc_addr),
  .int_sel   (int_sel),
  .ext_sel   (ext_sel)
);

// File: tb/shadow_route_top_test.sv
module shadow_route_top_test;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_off;
  logic [7:0]  cfg_wdata;
  logic        acc_valid;
  logic        acc_wr;
  logic [19:0] acc_addr;
  logic        int_sel;
  logic        ext_sel;

  int checks;
  int errors;
  bit done;

  shadow_route_top uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_off   (cfg_off),
    .cfg_wdata (cfg_wdata),
    .acc_valid (acc_valid),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr),
    .int_sel   (int_sel),
    .ext_sel   (ext_sel)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Vector: {cfg write, offset, data, address, wr, expected int_sel, req}
  localparam int NV = 20;
  localparam logic [42:0] VECS [NV] = '{
    {1'b0, 8'h00, 8'h00, 20'h00400, 1'b0, 1'b1, 4'd2},  // R2 low memory
    {1'b0, 8'h00, 8'h00, 20'hC0000, 1'b0, 1'b0, 4'd1},  // R1 reset routing
    {1'b1, 8'h47, 8'h01, 20'hC0000, 1'b1, 1'b1, 4'd4},  // R4 seg0 write bit
    {1'b0, 8'h00, 8'h00, 20'hC0000, 1'b0, 1'b0, 4'd7},  // R7 read stays external
    {1'b1, 8'h47, 8'h10, 20'hC0000, 1'b0, 1'b1, 4'd4},  // R4 seg0 read bit
    {1'b0, 8'h00, 8'h00, 20'hC0000, 1'b1, 1'b0, 4'd7},  // R7 write now external
    {1'b1, 8'h46, 8'h84, 20'hD8000, 1'b1, 1'b1, 4'd3},  // R3 seg6 write
    {1'b0, 8'h00, 8'h00, 20'hDC000, 1'b0, 1'b1, 4'd3},  // R3 seg7 read
    {1'b0, 8'h00, 8'h00, 20'hDC000, 1'b1, 1'b0, 4'd6},  // R6 seg7 write off
    {1'b0, 8'h00, 8'h00, 20'hD8000, 1'b0, 1'b0, 4'd6},  // R6 seg6 read off
    {1'b1, 8'h45, 8'h08, 20'hEC000, 1'b1, 1'b1, 4'd3},  // R3 seg11 write
    {1'b0, 8'h00, 8'h00, 20'hE8000, 1'b1, 1'b0, 4'd3},  // R3 seg10 write off
    {1'b1, 8'h44, 8'h02, 20'hF0000, 1'b0, 1'b1, 4'd5},  // R5 top read
    {1'b0, 8'h00, 8'h00, 20'hFFFFF, 1'b1, 1'b0, 4'd5},  // R5 top write off
    {1'b1, 8'h43, 8'hFF, 20'hE0000, 1'b1, 1'b0, 4'd9},  // R9 offset 0x43 ignored
    {1'b1, 8'h48, 8'hFF, 20'hC0000, 1'b1, 1'b0, 4'd9},  // R9 offset 0x48 ignored
    {1'b0, 8'h00, 8'h00, 20'hBFFFF, 1'b1, 1'b1, 4'd2},  // R2 just below window
    {1'b0, 8'h00, 8'h00, 20'hEFFFF, 1'b1, 1'b1, 4'd4},  // R4 last byte of seg11
    {1'b1, 8'h44, 8'hFC, 20'hF8000, 1'b0, 1'b0, 4'd5},  // R5 high bits no effect
    {1'b1, 8'h47, 8'hF0, 20'hCFFFF, 1'b0, 1'b1, 4'd4}   // R4 seg3 read
  };

  task automatic check_route(input int req, input logic exp_int);
    checks++;
    if (int_sel !== exp_int || ext_sel !== ~exp_int) begin
      errors++;
      $display("FAIL R%0d addr=%h wr=%b: int=%b ext=%b expected int=%b ext=%b",
               req, acc_addr, acc_wr, int_sel, ext_sel, exp_int, ~exp_int);
    end
  endtask

  task automatic apply(input logic cw, input logic [7:0] off, input logic [7:0] dat,
                       input logic [19:0] addr, input logic wr);
    @(negedge clk);
    cfg_we    = cw;
    cfg_off   = off;
    cfg_wdata = dat;
    acc_valid = 1'b0;
    @(negedge clk);
    cfg_we    = 1'b0;
    acc_addr  = addr;
    acc_wr    = wr;
    acc_valid = 1'b1;
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_off = '0; cfg_wdata = '0;
    acc_valid = 1'b0; acc_wr = 1'b0; acc_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state: top area write goes external
    apply(1'b0, 8'h00, 8'h00, 20'hF4000, 1'b1);
    check_route(1, 1'b0);

    for (int k = 0; k < NV; k++) begin
      apply(VECS[k][42], VECS[k][41:34], VECS[k][33:26], VECS[k][25:6], VECS[k][5]);
      check_route(int'(VECS[k][3:0]), VECS[k][4]);
    end

    // R8 idle: no select while acc_valid is low
    @(negedge clk);
    acc_valid = 1'b0;
    acc_addr  = 20'hC0000;
    #1;
    checks++;
    if (int_sel !== 1'b0 || ext_sel !== 1'b0) begin
      errors++;
      $display("FAIL R8 idle: int=%b ext=%b expected int=0 ext=0", int_sel, ext_sel);
    end

    // R9 timing: old routing holds until the capturing edge
    @(negedge clk);
    cfg_we = 1'b1; cfg_off = 8'h47; cfg_wdata = 8'h00;
    acc_addr = 20'hCFFFF; acc_wr = 1'b0; acc_valid = 1'b1;
    #1;
    check_route(9, 1'b1);
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    check_route(9, 1'b0);

    // R1 reset mid-run clears the bank: seg7 read returns to the bus
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    acc_addr = 20'hDC000; acc_wr = 1'b0; acc_valid = 1'b1;
    #1;
    check_route(1, 1'b0);
    // R2 low memory still internal after reset
    acc_addr = 20'h9F000;
    #1;
    check_route(2, 1'b1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule